// File: doc/BRIEF.md
# Dual-Domain Error Status Controller

This block keeps two separate banks of sticky error flags. One bank serves a management controller and the other serves the host. Both banks record events from one shared vector of error inputs. A small register port lets software read the banks, clear flags and program a control register. That register holds four things: the clear mode of the management bank, two auto-mask enables tied to two designated inputs, a PWM full-speed override flag, and a two-bit tachometer edge-select field. The tachometer field is stored and driven out, and the block does not act on it.

Each bank turns its contents into a summary flag. Software can read both summary flags in the control register, where they are read-only. The management summary, gated by an alert-enable input, drives the alert output. When an auto-mask enable is set and its designated input fires, the affected bank stops recording any further events. This lockout lasts until software clears that bank's own flag for the designated input, so a shutdown-type event is not buried under the follow-on faults it causes.

Top module: `errstat_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 00h, both banks are all zero, and alert_o and pwm_full_o are low.
- R2: Control bits 5:0 at address 0 are read/write. pwm_full_o follows bit 0 and tach_edge_o follows bits 5:4. A write takes effect on the clock edge at which it is presented.
- R3: A status bit is set on the edge after its event input is high and not masked. It stays set until it is cleared. An event in the same cycle as a clear of that bit leaves the bit set.
- R4: When control bit 1 is 1, a read of the management bank (address 1) returns its contents, and the bits returned are cleared at that edge. In this mode, writes to address 1 have no effect.
- R5: When control bit 1 is 0, writing a 1 to a bit of address 1 clears that management bit. Writing a 1 to a bit of address 2 always clears that host bit. Reads never clear the host bank.
- R6: When control bit 2 is 1, a bank whose bit 4 is set records no new events until that bank's own bit 4 is cleared. The event on input 4 that sets the bit is itself recorded. Each bank is masked independently of the other.
- R7: Control bit 3 gives the same behaviour as R6 for input 5 and status bit 5.
- R8: An event that arrives while a bank is masked is discarded. It does not appear after the mask is released.
- R9: Control bit 7 reads 1 when any management bit is set, and bit 6 reads 1 when any host bit is set. Writes to bits 7:6 are ignored. Address 3 reads zero.
- R10: alert_o is high exactly when alert_en is high and at least one management bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 8 | Error event pulses, one per bit |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 control, 1 management bank, 2 host bank |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| alert_en | input | 1 | Alert enable |
| alert_o | output | 1 | Management alert |
| pwm_full_o | output | 1 | Forces all PWM channels to full duty |
| tach_edge_o | output | 2 | Tachometer edge-select field |

## Verification
The directed cases cover four distinctions:
- A lone event separates set from clear.
- An event that coincides with a write-one-to-clear separates "event wins" from "clear wins".
- Two reads in a row under clear-on-read separate that mode from write-one-to-clear.
- A trigger on input 4 or 5 followed by other events, with only one bank's designated bit cleared, shows whether masking is held per bank and whether dropped events are lost for good.

Seeded random traffic then mixes sparse events, random writes and reads, and clear-mode switches. It compares every read and the alert, PWM and tachometer outputs with a bench model built from the requirements.

// File: rtl/errstat_pkg.sv
// Shared constants for the dual-domain error status controller.
// Assumes an 8-bit register port with a 2-bit address.
package errstat_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int CTRL_W = 6;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MGMT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_HOST = 2'd2;

    // Control bit positions (software visible, so fixed)
    localparam int CB_PWM  = 0;
    localparam int CB_COR  = 1;
    localparam int CB_AMA  = 2;
    localparam int CB_AMB  = 3;
    localparam int CB_TACH = 4;

    localparam int BANK_MGMT = 0;
    localparam int BANK_HOST = 1;
    localparam int N_BANK    = 2;
endpackage

// File: rtl/errstat_ctrlreg.sv
// Control register: holds the writable control bits.
// Assumes the caller decodes the address. Read-only bits are not stored here.
module errstat_ctrlreg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);
    // Hold the control value and load it on a decoded write
    always_ff @(posedge clk) begin
        if (!rst_n)    q_o <= '0;
        else if (we_i) q_o <= wdata_i;
    end

    // R2
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (q_o == $past(wdata_i)));

    // R2
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(q_o));
endmodule

// File: rtl/errstat_bank.sv
// One bank of sticky error flags.
// Behaviour:
// - A flag sets on an accepted event.
// - A flag clears through clr_i.
// - When a clear and an event hit the same bit in one cycle, the event wins.
// - When an auto-mask enable is set and the bank's designated flag is already
//   set, every incoming event is discarded.
// Assumes SA and SB are distinct indices below W.
module errstat_bank #(
    parameter int W  = 8,
    parameter int SA = 4,
    parameter int SB = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_i,
    input  logic         am_a_i,
    input  logic         am_b_i,
    output logic [W-1:0] stat_o
);
    logic         locked;
    logic [W-1:0] accepted;

    // Lockout uses the flags as they stand before this cycle's update
    always_comb begin
        locked   = (am_a_i && stat_o[SA]) || (am_b_i && stat_o[SB]);
        accepted = locked ? '0 : evt_i;
    end

    // Sticky flag storage: clear first, then OR in accepted events
    always_ff @(posedge clk) begin
        if (!rst_n) stat_o <= '0;
        else        stat_o <= (stat_o & ~clr_i) | accepted;
    end

    // R3
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & $past(stat_o & ~clr_i)) == $past(stat_o & ~clr_i)));

    // R3
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((stat_o & ~$past(stat_o)) & ~$past(evt_i)) == '0));

    // R3
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(am_a_i && stat_o[SA]) && !(am_b_i && stat_o[SB]))
            |=> ((stat_o & $past(evt_i)) == $past(evt_i)));

    // R6
    mask_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (am_a_i && stat_o[SA]) |=> ((stat_o & ~$past(stat_o)) == '0));

    // R7
    mask_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (am_b_i && stat_o[SB]) |=> ((stat_o & ~$past(stat_o)) == '0));
endmodule

// File: rtl/errstat_ctrl.sv
// Dual-domain error status controller, top level.
// Structure:
// - Two sticky banks share one event vector.
// - A control register selects the management clear mode, the auto-masks,
//   the PWM override and the tachometer edge field.
// - Read data is combinational from addr.
// Clear-on-read clears the bits returned, at the edge of the read strobe.
// Assumes N_EVT equals the register data width.
module errstat_ctrl
    import errstat_pkg::*;
#(
    parameter int N_EVT = DATA_W,
    parameter int SPEC_A = 4,
    parameter int SPEC_B = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EVT-1:0]  evt_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              alert_en,
    output logic              alert_o,
    output logic              pwm_full_o,
    output logic [1:0]        tach_edge_o
);
    logic [CTRL_W-1:0]             ctrl_q;
    logic [N_BANK-1:0][N_EVT-1:0]  stat_q;
    logic [N_BANK-1:0][N_EVT-1:0]  clr;
    logic                          cor_mode;
    logic                          mgmt_any;
    logic                          host_any;

    errstat_ctrlreg #(.W(CTRL_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en && addr == ADDR_CTRL),
        .wdata_i (wdata[CTRL_W-1:0]),
        .q_o     (ctrl_q)
    );

    // Derive the clear vector for each bank from the port strobes
    always_comb begin
        cor_mode = ctrl_q[CB_COR];
        clr[BANK_MGMT] = '0;
        if (cor_mode) begin
            if (rd_en && addr == ADDR_MGMT) clr[BANK_MGMT] = stat_q[BANK_MGMT];
        end else if (wr_en && addr == ADDR_MGMT) begin
            clr[BANK_MGMT] = wdata[N_EVT-1:0];
        end
        clr[BANK_HOST] = (wr_en && addr == ADDR_HOST) ? wdata[N_EVT-1:0] : '0;
    end

    for (genvar g = 0; g < N_BANK; g++) begin : g_bank
        errstat_bank #(.W(N_EVT), .SA(SPEC_A), .SB(SPEC_B)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_i  (evt_i),
            .clr_i  (clr[g]),
            .am_a_i (ctrl_q[CB_AMA]),
            .am_b_i (ctrl_q[CB_AMB]),
            .stat_o (stat_q[g])
        );
    end

    // Summaries, alert and control-driven outputs
    always_comb begin
        mgmt_any    = |stat_q[BANK_MGMT];
        host_any    = |stat_q[BANK_HOST];
        alert_o     = alert_en && mgmt_any;
        pwm_full_o  = ctrl_q[CB_PWM];
        tach_edge_o = ctrl_q[CB_TACH+1:CB_TACH];
    end

    // Read data multiplexer
    always_comb begin
        case (addr)
            ADDR_CTRL: rdata = {mgmt_any, host_any, ctrl_q};
            ADDR_MGMT: rdata = stat_q[BANK_MGMT];
            ADDR_HOST: rdata = stat_q[BANK_HOST];
            default:   rdata = '0;
        endcase
    end

    // R5
    host_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == ADDR_HOST)
            |=> ((stat_q[BANK_HOST] & $past(stat_q[BANK_HOST])) == $past(stat_q[BANK_HOST])));
endmodule

// File: tb/errstat_ctrl_bench.sv
// Self-checking bench for errstat_ctrl. A reference model is built from the
// requirements. Directed cases come first, then seeded random traffic.
module errstat_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] evt_i;
    logic       wr_en, rd_en;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       alert_en;
    logic       alert_o, pwm_full_o;
    logic [1:0] tach_edge_o;

    int n_cmp = 0;
    int n_bad = 0;

    // model state
    logic [5:0] m_ctrl;
    logic [7:0] m_mg, m_hs;

    always #4 clk = ~clk;   // 125 MHz

    errstat_ctrl u_errstat_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .alert_en(alert_en),
        .alert_o(alert_o), .pwm_full_o(pwm_full_o), .tach_edge_o(tach_edge_o)
    );

    function automatic logic [7:0] bank_next(logic [7:0] cur, logic [7:0] ev,
                                             logic [7:0] cl, logic ama, logic amb);
        logic lk;
        lk = (ama && cur[4]) || (amb && cur[5]);
        return (cur & ~cl) | (lk ? 8'h00 : ev);
    endfunction

    function automatic logic [7:0] model_read(logic [1:0] a);
        case (a)
            2'd0: return {|m_mg, |m_hs, m_ctrl};
            2'd1: return m_mg;
            2'd2: return m_hs;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // One cycle: drive after negedge, check before the edge, update the model at the edge
    task automatic cyc(logic [7:0] ev, logic w, logic r, logic [1:0] a,
                       logic [7:0] d, string tag);
        logic [7:0] cmg, chs;
        @(negedge clk);
        evt_i = ev; wr_en = w; rd_en = r; addr = a; wdata = d;
        #2;
        if (r) check(tag, rdata, model_read(a));
        check("R10 alert", {7'd0, alert_o}, {7'd0, alert_en && (m_mg != 0)});
        check("R2 outputs", {5'd0, tach_edge_o, pwm_full_o}, {5'd0, m_ctrl[5:4], m_ctrl[0]});
        cmg = 8'h00;
        if (m_ctrl[1]) begin
            if (r && a == 2'd1) cmg = m_mg;
        end else if (w && a == 2'd1) cmg = d;
        chs = (w && a == 2'd2) ? d : 8'h00;
        @(posedge clk);
        m_mg = bank_next(m_mg, ev, cmg, m_ctrl[2], m_ctrl[3]);
        m_hs = bank_next(m_hs, ev, chs, m_ctrl[2], m_ctrl[3]);
        if (w && a == 2'd0) m_ctrl = d[5:0];
    endtask

    task automatic rd(logic [1:0] a, string tag);
        cyc(8'h00, 1'b0, 1'b1, a, 8'h00, tag);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        cyc(8'h00, 1'b1, 1'b0, a, d, "write");
    endtask

    // Watchdog: an expired timer is a failed check
    initial begin
        #1_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; evt_i = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; alert_en = 1'b1;
        m_ctrl = 0; m_mg = 0; m_hs = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, "R1 ctrl");
        rd(2'd1, "R1 mgmt");
        rd(2'd2, "R1 host");
        check("R1 rdata literal", model_read(2'd0), 8'h00);

        // R2 read/write control
        wr(2'd0, 8'h31);
        rd(2'd0, "R2 ctrl readback");
        check("R2 pwm", {7'd0, pwm_full_o}, 8'h01);
        // R9 writes to read-only bits ignored
        wr(2'd0, 8'hC0);
        rd(2'd0, "R9 ro bits");
        rd(2'd3, "R9 addr3 zero");

        // R3 sticky set, event wins over clear
        cyc(8'h01, 0, 0, 2'd0, 8'h00, "R3");
        rd(2'd1, "R3 mgmt set");
        rd(2'd2, "R3 host set");
        rd(2'd0, "R9 summaries");
        cyc(8'h01, 1, 0, 2'd2, 8'h01, "R3");
        rd(2'd2, "R3 event wins");
        // R5 host reads do not clear, W1C clears
        rd(2'd2, "R5 host read keeps");
        wr(2'd2, 8'h01);
        rd(2'd2, "R5 host w1c");
        // R10 alert gating
        alert_en = 1'b0;
        rd(2'd1, "R10 gated");
        alert_en = 1'b1;
        // R5 mgmt w1c
        wr(2'd1, 8'h01);
        rd(2'd1, "R5 mgmt w1c");

        // R4 clear-on-read
        wr(2'd0, 8'h02);
        cyc(8'h06, 0, 0, 2'd0, 8'h00, "R4");
        wr(2'd1, 8'hFF);
        rd(2'd1, "R4 write ignored");
        rd(2'd1, "R4 cleared by read");
        rd(2'd2, "R4 host unaffected");
        wr(2'd2, 8'hFF);

        // R6 auto-mask on input 4, per bank
        wr(2'd0, 8'h04);
        cyc(8'h10, 0, 0, 2'd0, 8'h00, "R6");
        cyc(8'h02, 0, 0, 2'd0, 8'h00, "R6");
        rd(2'd1, "R6 mgmt masked");
        wr(2'd2, 8'h10);
        cyc(8'h04, 0, 0, 2'd0, 8'h00, "R6");
        rd(2'd2, "R6 host released");
        rd(2'd1, "R6 mgmt still masked");
        wr(2'd1, 8'h10);
        rd(2'd1, "R8 dropped not held");
        check("R8 literal", model_read(2'd1), 8'h00);
        wr(2'd2, 8'hFF);

        // R7 auto-mask on input 5
        wr(2'd0, 8'h08);
        cyc(8'h20, 0, 0, 2'd0, 8'h00, "R7");
        cyc(8'h81, 0, 0, 2'd0, 8'h00, "R7");
        rd(2'd1, "R7 mgmt masked");
        rd(2'd2, "R7 host masked");
        wr(2'd1, 8'h20);
        cyc(8'h40, 0, 0, 2'd0, 8'h00, "R7");
        rd(2'd1, "R7 released");

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] ev, d;
            logic [1:0] a;
            logic w, r;
            int k;
            ev = 8'h00;
            k = $urandom_range(0, 9);
            if (k < 3) ev = 8'h01 << $urandom_range(0, 7);
            else if (k == 3) ev = 8'($urandom);
            a = 2'($urandom_range(0, 3));
            w = ($urandom_range(0, 7) == 0);
            r = ($urandom_range(0, 2) == 0);
            d = 8'($urandom);
            if (w && a == 2'd0 && $urandom_range(0, 3) != 0) d[1] = 1'b0;
            alert_en = ($urandom_range(0, 4) != 0);
            cyc(ev, w, r, a, d, "R3 R4 R5 R6 R7 R9 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule